// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the integer register store of a 32-bit processor core. Sixteen logical registers, r0 to r15, are visible at any moment. The physical register behind each logical index depends on the operating mode held in the low five bits of the current status word. Physical storage is 31 general-purpose words and six status words. The six status words are one current status word and one saved status word for each of the five exception modes. r15 holds the program counter, and its read value is aligned to the instruction state. r14 is the link register: a branch-with-link strobe copies the aligned program counter into the r14 of the current mode. An exception-entry strobe does three things on one clock edge. It stores a return address into the r14 of the mode being entered, copies the current status word into that mode's saved status word, and switches the mode.

The core uses two combinational read ports and one write port, each addressed by a 4-bit logical index. Mode changes come from two sources: a write to the current status word, or the exception strobe. All ports are plain strobes with no back-pressure. Every write, link or exception strobe is accepted in the cycle it is asserted, so no port has a ready signal. Reads see a word being written in the same cycle (write-first). The status outputs are registered and change one edge after the strobe.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every logical register reads 0 in every mode, cpsr_o reads 0x00000013 (supervisor), and spsr_o reads 0.
- R2: The mode field is cpsr_o[4:0], with these codes: user 10000, FIQ 10001, IRQ 10010, supervisor 10011, abort 10111, undefined 11011, system 11111. Any other code selects the user bank.
- R3: In FIQ mode, r8 to r14 are private to FIQ. r0 to r7 and r15 are shared with every other mode.
- R4: IRQ, supervisor, abort and undefined modes each have a private r13 and r14. Their r0 to r12 and r15 are the user registers.
- R5: System mode uses the user bank for all sixteen registers. In user and system mode, spsr_o reads 0.
- R6: When thumb_i is 0, reads of r15 return bits [1:0] as 0. When thumb_i is 1, they return bit 0 as 0. The upper bits are the stored value.
- R7: link_i writes the stored r15, aligned as in R6, into the current mode's r14 at the next rising edge. If the write port targets r14 in the same cycle, link_i takes priority.
- R8: exc_i with exc_mode_i naming FIQ, IRQ, supervisor, abort or undefined does three things at the next edge. It writes exc_ret_i into that mode's r14, copies cpsr_o into that mode's saved word, and replaces cpsr_o[4:0] with exc_mode_i. The write port, link_i and psr_we_i are ignored in that cycle. exc_i naming any other code has no effect.
- R9: A read port addressing the register being written in the same cycle returns the new value (write-first).
- R10: psr_we_i with psr_sel_i=0 loads cpsr_o from psr_wdata_i at the next edge. With psr_sel_i=1 it loads the current mode's saved word, but only in an exception mode; in user or system mode it has no effect. cpsr_o is otherwise held.
- R11: Writes take effect at the rising edge. The two read ports address registers independently, through the current mode's bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Read port A logical index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B logical index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write port strobe |
| wr_idx | input | 4 | Write port logical index |
| wr_data | input | 32 | Write port data |
| thumb_i | input | 1 | Instruction state, 1 = 16-bit instructions |
| link_i | input | 1 | Branch-with-link strobe |
| exc_i | input | 1 | Exception-entry strobe |
| exc_mode_i | input | 5 | Mode code being entered |
| exc_ret_i | input | 32 | Return address for the entered mode's r14 |
| psr_we_i | input | 1 | Status write strobe |
| psr_sel_i | input | 1 | 0 = current status word, 1 = saved status word |
| psr_wdata_i | input | 32 | Status write data |
| cpsr_o | output | 32 | Current status word |
| spsr_o | output | 32 | Saved status word of the current mode, 0 in user/system |

## Verification
Read data is due in the same cycle as its address. A write, link or exception strobe in that cycle is already visible on the read ports, through the current bank. Register contents and the mode seen by the read ports change only at the following rising edge. cpsr_o and spsr_o change one edge after a status write or exception strobe. The bench drives inputs at the falling edge and samples all four outputs one nanosecond later. It compares them with a model that has applied that cycle's writes but still uses the old mode and status words, then commits the model at the rising edge.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

  localparam int NUM_LOGICAL = 16;
  localparam int NUM_SAVED   = 5;
  localparam int NUM_GPR     = 31;
  localparam int PHYS_W      = 5;
  localparam int MODE_W      = 5;
  localparam int IDX_W       = 4;
  localparam int PC_IDX      = 15;
  localparam int LINK_IDX    = 14;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_code_e;

  // Bank selector; BK_USR also serves system mode and unknown codes.
  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  function automatic bank_e decode_bank(input logic [MODE_W-1:0] code);
    case (code)
      MODE_FIQ: return BK_FIQ;
      MODE_IRQ: return BK_IRQ;
      MODE_SVC: return BK_SVC;
      MODE_ABT: return BK_ABT;
      MODE_UND: return BK_UND;
      default:  return BK_USR;
    endcase
  endfunction

endpackage

// File: rtl/bank_map.sv
module bank_map
  import bankreg_pkg::*;
(
  input  bank_e             bank,
  input  logic [IDX_W-1:0]  idx,
  output logic [PHYS_W-1:0] phys
);

  localparam int FIQ_BASE  = NUM_LOGICAL;       // 16..22: FIQ r8..r14
  localparam int PAIR_BASE = NUM_LOGICAL + 7;   // 23..30: r13/r14 pairs
  localparam int FIQ_LO    = 8;
  localparam int PAIR_LO   = 13;

  always_comb begin
    int off;
    phys = PHYS_W'(idx);
    off  = 0;
    if (bank == BK_FIQ && idx >= IDX_W'(FIQ_LO) && idx <= IDX_W'(LINK_IDX)) begin
      phys = PHYS_W'(FIQ_BASE) + PHYS_W'(idx - IDX_W'(FIQ_LO));
    end else if (bank != BK_USR && bank != BK_FIQ &&
                 idx >= IDX_W'(PAIR_LO) && idx <= IDX_W'(LINK_IDX)) begin
      off  = 2 * (int'(bank) - int'(BK_IRQ));
      phys = PHYS_W'(PAIR_BASE + off) + PHYS_W'(idx - IDX_W'(PAIR_LO));
    end
    p_phys_in_range_r2: assert (int'(phys) < NUM_GPR);
  end

endmodule

// File: rtl/gpr_array.sv
module gpr_array
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wa_en,
  input  logic [PHYS_W-1:0]   wa_idx,
  input  logic [DATA_W-1:0]   wa_data,
  input  logic                wb_en,
  input  logic [PHYS_W-1:0]   wb_idx,
  input  logic [DATA_W-1:0]   wb_data,
  input  logic                wc_en,
  input  logic [PHYS_W-1:0]   wc_idx,
  input  logic [DATA_W-1:0]   wc_data,
  output logic [DATA_W-1:0]   nxt_o [NUM_GPR],
  output logic [DATA_W-1:0]   pc_q_o
);

  logic [DATA_W-1:0] q [NUM_GPR];

  // Per physical word: exception port over link port over general port.
  for (genvar g = 0; g < NUM_GPR; g++) begin : g_word
    always_comb begin
      nxt_o[g] = q[g];
      if (wa_en && wa_idx == PHYS_W'(g)) nxt_o[g] = wa_data;
      if (wb_en && wb_idx == PHYS_W'(g)) nxt_o[g] = wb_data;
      if (wc_en && wc_idx == PHYS_W'(g)) nxt_o[g] = wc_data;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) q[g] <= '0;
      else        q[g] <= nxt_o[g];
    end
  end

  assign pc_q_o = q[PC_IDX];

  p_link_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !wc_en) |=> (q[$past(wb_idx)] == $past(wb_data)));

  p_exc_link_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wc_en |=> (q[$past(wc_idx)] == $past(wc_data)));

endmodule

// File: rtl/psr_bank.sv
module psr_bank
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_e             cur_bank,
  input  bank_e             exc_bank,
  input  logic              exc_en,
  input  logic [MODE_W-1:0] exc_code,
  input  logic              psr_we,
  input  logic              psr_sel,
  input  logic [DATA_W-1:0] psr_wdata,
  output logic [DATA_W-1:0] cpsr_q,
  output logic [DATA_W-1:0] spsr_o
);

  localparam logic [DATA_W-1:0] CPSR_RST = DATA_W'(MODE_SVC);

  logic [DATA_W-1:0] cpsr_d;
  logic [DATA_W-1:0] spsr_q [NUM_SAVED];

  always_comb begin
    cpsr_d = cpsr_q;
    if (exc_en)                  cpsr_d = {cpsr_q[DATA_W-1:MODE_W], exc_code};
    else if (psr_we && !psr_sel) cpsr_d = psr_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cpsr_q <= CPSR_RST;
    else        cpsr_q <= cpsr_d;
  end

  for (genvar k = 0; k < NUM_SAVED; k++) begin : g_saved
    localparam bank_e OWNER = bank_e'(k + 1);
    always_ff @(posedge clk) begin
      if (!rst_n)
        spsr_q[k] <= '0;
      else if (exc_en && exc_bank == OWNER)
        spsr_q[k] <= cpsr_q;
      else if (!exc_en && psr_we && psr_sel && cur_bank == OWNER)
        spsr_q[k] <= psr_wdata;
    end
  end

  always_comb begin
    spsr_o = '0;
    for (int k = 0; k < NUM_SAVED; k++)
      if (cur_bank == bank_e'(k + 1)) spsr_o = spsr_q[k];
  end

  p_exc_saves_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_en |=> (cpsr_q[MODE_W-1:0] == $past(exc_code)) && (spsr_o == $past(cpsr_q)));

  p_cpsr_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_en && !(psr_we && !psr_sel)) |=> $stable(cpsr_q));

  p_spsr_loaded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_en && psr_we && psr_sel && cur_bank != BK_USR) |=> (spsr_o == $past(psr_wdata)));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              thumb_i,
  input  logic              link_i,
  input  logic              exc_i,
  input  logic [4:0]        exc_mode_i,
  input  logic [DATA_W-1:0] exc_ret_i,
  input  logic              psr_we_i,
  input  logic              psr_sel_i,
  input  logic [DATA_W-1:0] psr_wdata_i,
  output logic [DATA_W-1:0] cpsr_o,
  output logic [DATA_W-1:0] spsr_o
);

  // Mapper slots: read A, read B, write port, link target, exception target.
  localparam int NUM_MAPS = 5;
  localparam int M_RDA = 0, M_RDB = 1, M_WR = 2, M_LNK = 3, M_EXC = 4;

  logic [DATA_W-1:0] cpsr_q;
  bank_e             cur_bank, exc_bank;
  logic              exc_ok;
  bank_e             map_bank [NUM_MAPS];
  logic [IDX_W-1:0]  map_idx  [NUM_MAPS];
  logic [PHYS_W-1:0] map_phys [NUM_MAPS];
  logic [DATA_W-1:0] nxt [NUM_GPR];
  logic [DATA_W-1:0] pc_q, pc_mask, link_val;
  logic              wa_en, wb_en;

  assign cur_bank = decode_bank(cpsr_q[MODE_W-1:0]);
  assign exc_bank = decode_bank(exc_mode_i);
  assign exc_ok   = exc_i && (exc_bank != BK_USR);

  always_comb begin
    map_bank[M_RDA] = cur_bank; map_idx[M_RDA] = rd_a_idx;
    map_bank[M_RDB] = cur_bank; map_idx[M_RDB] = rd_b_idx;
    map_bank[M_WR]  = cur_bank; map_idx[M_WR]  = wr_idx;
    map_bank[M_LNK] = cur_bank; map_idx[M_LNK] = IDX_W'(LINK_IDX);
    map_bank[M_EXC] = exc_bank; map_idx[M_EXC] = IDX_W'(LINK_IDX);
  end

  for (genvar m = 0; m < NUM_MAPS; m++) begin : g_map
    bank_map u_map (
      .bank (map_bank[m]),
      .idx  (map_idx[m]),
      .phys (map_phys[m])
    );
  end

  assign pc_mask  = thumb_i ? ~DATA_W'(1) : ~DATA_W'(3);
  assign link_val = pc_q & pc_mask;
  assign wa_en    = wr_en && !exc_ok && !(link_i && wr_idx == IDX_W'(LINK_IDX));
  assign wb_en    = link_i && !exc_ok;

  gpr_array #(.DATA_W(DATA_W)) u_gpr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wa_en   (wa_en),
    .wa_idx  (map_phys[M_WR]),
    .wa_data (wr_data),
    .wb_en   (wb_en),
    .wb_idx  (map_phys[M_LNK]),
    .wb_data (link_val),
    .wc_en   (exc_ok),
    .wc_idx  (map_phys[M_EXC]),
    .wc_data (exc_ret_i),
    .nxt_o   (nxt),
    .pc_q_o  (pc_q)
  );

  psr_bank #(.DATA_W(DATA_W)) u_psr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_bank  (cur_bank),
    .exc_bank  (exc_bank),
    .exc_en    (exc_ok),
    .exc_code  (exc_mode_i),
    .psr_we    (psr_we_i && !exc_ok),
    .psr_sel   (psr_sel_i),
    .psr_wdata (psr_wdata_i),
    .cpsr_q    (cpsr_q),
    .spsr_o    (spsr_o)
  );

  // Write-first: reads select from the next-state view.
  always_comb begin
    rd_a_data = nxt[map_phys[M_RDA]];
    rd_b_data = nxt[map_phys[M_RDB]];
    if (rd_a_idx == IDX_W'(PC_IDX)) rd_a_data = rd_a_data & pc_mask;
    if (rd_b_idx == IDX_W'(PC_IDX)) rd_b_data = rd_b_data & pc_mask;
  end

  assign cpsr_o = cpsr_q;

  p_pc_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 4'd15) |-> (rd_a_data[0] == 1'b0) && (thumb_i || rd_a_data[1] == 1'b0));

  p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !exc_i && wr_idx == rd_a_idx && wr_idx != 4'd15 &&
     !(link_i && wr_idx == 4'd14)) |-> (rd_a_data == wr_data));

endmodule

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  ra, rb, wi;
  logic [31:0] rda, rdb, wd, eret, pwd, cpsr, spsr;
  logic        we, thumb, lnk, exc, pwe, psel;
  logic [4:0]  emode;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Mode list used by the model: 0 usr,1 fiq,2 irq,3 svc,4 abt,5 und,6 sys
  logic [31:0] v  [7][16];
  logic [31:0] nv [7][16];
  logic [31:0] msp [5];
  logic [31:0] nsp [5];
  logic [31:0] mcpsr, ncpsr;

  always #4 clk = ~clk;

  banked_regfile i_banked_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(ra), .rd_a_data(rda), .rd_b_idx(rb), .rd_b_data(rdb),
    .wr_en(we), .wr_idx(wi), .wr_data(wd), .thumb_i(thumb), .link_i(lnk),
    .exc_i(exc), .exc_mode_i(emode), .exc_ret_i(eret),
    .psr_we_i(pwe), .psr_sel_i(psel), .psr_wdata_i(pwd),
    .cpsr_o(cpsr), .spsr_o(spsr)
  );

  function automatic int mode_of(input logic [4:0] c);
    case (c)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      5'b11111: return 6;
      default:  return 0;
    endcase
  endfunction

  function automatic bit banks(input int k, input int i);
    if (k == 1) return (i >= 8 && i <= 14);
    if (k >= 2 && k <= 5) return (i == 13 || i == 14);
    return 0;
  endfunction

  task automatic mw(input int k, input int i, input logic [31:0] val);
    for (int j = 0; j < 7; j++)
      if (j == k || (!banks(j, i) && !banks(k, i))) nv[j][i] = val;
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Called just after a falling edge with inputs set.
  task automatic step(input string tag);
    int k, ek;
    logic [31:0] mask, ea, eb;
    #1;
    k    = mode_of(mcpsr[4:0]);
    ek   = mode_of(emode);
    mask = thumb ? 32'hFFFF_FFFE : 32'hFFFF_FFFC;
    nv = v; nsp = msp; ncpsr = mcpsr;
    if (exc && ek >= 1 && ek <= 5) begin
      mw(ek, 14, eret);
      nsp[ek-1] = mcpsr;
      ncpsr = {mcpsr[31:5], emode};
    end else begin
      if (we && !(lnk && wi == 4'd14)) mw(k, int'(wi), wd);
      if (lnk) mw(k, 14, v[k][15] & mask);
      if (pwe) begin
        if (!psel) ncpsr = pwd;
        else if (k >= 1 && k <= 5) nsp[k-1] = pwd;
      end
    end
    ea = nv[k][ra]; if (ra == 4'd15) ea = ea & mask;
    eb = nv[k][rb]; if (rb == 4'd15) eb = eb & mask;
    check(tag, "rd_a_data", rda, ea);
    check(tag, "rd_b_data", rdb, eb);
    check(tag, "cpsr_o", cpsr, mcpsr);
    check(tag, "spsr_o", spsr, (k >= 1 && k <= 5) ? msp[k-1] : 32'h0);
    @(posedge clk);
    v = nv; msp = nsp; mcpsr = ncpsr;
    @(negedge clk);
    we = 0; lnk = 0; exc = 0; pwe = 0; psel = 0;
  endtask

  task automatic wr(input int i, input logic [31:0] d, input string tag);
    we = 1; wi = 4'(i); wd = d; ra = 4'(i); rb = 4'(15 - i);
    step(tag);
  endtask

  task automatic set_mode(input logic [31:0] c, input string tag);
    pwe = 1; psel = 0; pwd = c;
    step(tag);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 16; i++) begin
      ra = 4'(i); rb = 4'(15 - i);
      step(tag);
    end
  endtask

  initial begin
    rst_n = 0; ra = 0; rb = 0; wi = 0; wd = 0; we = 0; thumb = 0; lnk = 0;
    exc = 0; emode = 0; eret = 0; pwe = 0; psel = 0; pwd = 0;
    for (int j = 0; j < 7; j++) for (int i = 0; i < 16; i++) v[j][i] = 0;
    for (int j = 0; j < 5; j++) msp[j] = 0;
    mcpsr = 32'h13;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    sweep("R1");
    // R11: fill the supervisor view
    for (int i = 0; i < 16; i++) wr(i, 32'h1000_0000 + 32'(i * 17), "R11");
    // R9: same-cycle read of a written word
    we = 1; wi = 5; wd = 32'hDEAD_BEE0; ra = 5; rb = 5; step("R9");
    // R8: enter FIQ, competing writes ignored
    exc = 1; emode = 5'b10001; eret = 32'h0000_1004;
    we = 1; wi = 3; wd = 32'hAAAA_AAAA; pwe = 1; psel = 0; pwd = 32'h10;
    ra = 14; rb = 3; step("R8");
    ra = 14; rb = 3; step("R8");
    // R3: FIQ private r8..r14
    for (int i = 8; i < 15; i++) wr(i, 32'hF000_0000 + 32'(i), "R3");
    wr(2, 32'h2222_0002, "R3");
    set_mode(32'h10, "R10");
    sweep("R3");
    // R2: unknown codes behave as user
    set_mode(32'h15, "R2"); sweep("R2");
    set_mode(32'h00, "R2"); ra = 13; rb = 8; step("R2");
    // R5: system shares user bank, no saved word
    set_mode(32'h1F, "R5");
    wr(13, 32'h5555_0013, "R5");
    pwe = 1; psel = 1; pwd = 32'h1234_5678; ra = 13; rb = 14; step("R10");
    set_mode(32'h10, "R5"); ra = 13; rb = 14; step("R5");
    // R4: IRQ private r13/r14
    exc = 1; emode = 5'b10010; eret = 32'h0000_2000; step("R8");
    sweep("R4");
    wr(13, 32'h1313_0002, "R4");
    pwe = 1; psel = 1; pwd = 32'h0000_ABCD; step("R10");
    ra = 13; rb = 0; step("R10");
    // R6: r15 alignment
    wr(15, 32'h0000_2003, "R6");
    thumb = 0; ra = 15; rb = 15; step("R6");
    thumb = 1; ra = 15; rb = 14; step("R6");
    // R7: link in thumb state, then link against write to r14
    lnk = 1; ra = 14; rb = 15; step("R7");
    thumb = 0;
    lnk = 1; we = 1; wi = 14; wd = 32'h7777_7777; ra = 14; rb = 13; step("R7");
    lnk = 1; we = 1; wi = 2; wd = 32'h0202_0202; ra = 2; rb = 14; step("R7");
    // R8: invalid targets have no effect
    exc = 1; emode = 5'b10000; eret = 32'h999; we = 1; wi = 1; wd = 32'h0101_0101;
    ra = 14; rb = 1; step("R8");
    exc = 1; emode = 5'b11111; eret = 32'h998; ra = 14; rb = 1; step("R8");
    exc = 1; emode = 5'b11011; eret = 32'h0000_3008; ra = 14; rb = 13; step("R8");
    exc = 1; emode = 5'b10111; eret = 32'h0000_400C; lnk = 1; ra = 14; rb = 14; step("R8");
    exc = 1; emode = 5'b10011; eret = 32'h0000_5010; ra = 14; rb = 13; step("R8");
    ra = 14; rb = 0; step("R8");
    // R11: every mode view, with a distinct write per mode
    begin
      logic [4:0] codes [8];
      codes = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                5'b10111, 5'b11011, 5'b11111, 5'b00111};
      for (int c = 0; c < 8; c++) begin
        set_mode({27'h0, codes[c]}, "R2");
        wr(13, 32'hC0DE_0000 + 32'(c), "R4");
        wr(9, 32'h9999_0000 + 32'(c), "R3");
        sweep("R11");
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule